// File: doc/BRIEF.md
# Auxiliary Input Current Ramp Regulator

This block is the control logic that sets the input current limit of the buck charger fed from the auxiliary charge input, once trickle charging has completed. It starts the buck at its lowest setting. After that it compares the auxiliary voltage against three comparator levels (weak, mid and high) and moves through a hysteretic window. Above the mid level the limit climbs slowly, one code per long ramp period. Between the weak and mid levels it holds. Once holding, it climbs again only after the input has passed the high level. Below the weak level it backs off quickly, one code per short period. If the input is still weak at the minimum code, the buck is switched off and a weak-input interrupt pulse is raised.

Both periods come from one shared prescaler. The prescaler division and the tick counts of the two periods are parameters; the defaults give about 100 ms and 120 µs at 200 MHz. Limit code k stands for (k+1) × 100 mA. A dead-battery lockout watches the downward steps. A step that lands below a parameterised code (250 mA by default), while the battery switch is present, the source is rated for 500 mA or more, the system is on and the battery is below its minimum, requests a rail power-down. It also inhibits power-on until the battery recovers.

Top module: `aux_ilim_ramp`

## Requirements
- R1: While reset is active and after it, until trickle_done rises, the outputs read ilim_code = 0, buck_en = 0, weak_irq = 0, rails_off = 0 and pwr_inhibit = 0.
- R2: One clock edge after trickle_done is seen high from idle, buck_en = 1 and ilim_code = 0 (100 mA), and the block is in the increasing mode.
- R3: In the increasing mode, with above_mid = 1 and aux_en = 1, ilim_code rises by exactly 1 on the edge that ends each PRESCALE × RAMP_TICKS cycles spent there. It saturates at the all-ones code and never wraps.
- R4: In the increasing mode, above_weak = 1 with above_mid = 0 moves the block to the hold mode on the next edge. ilim_code stays fixed, and the partial ramp period is discarded.
- R5: In the hold mode, the block returns to the increasing mode only when above_high = 1. With above_mid = 1 but above_high = 0 it keeps holding. After the return, the first step comes a full ramp period later.
- R6: In the increasing or hold mode, above_weak = 0 moves the block to the back-off mode on the next edge. There ilim_code falls by exactly 1 at the end of every PRESCALE × BACK_TICKS cycles.
- R7: In the back-off mode, above_weak = 1 moves the block to the hold mode on the next edge, and the code stops falling.
- R8: When a back-off period ends with ilim_code = 0, buck_en goes to 0 and weak_irq is 1 for exactly one cycle on the same edge. The buck stays off while trickle_done stays high, whatever the comparators do.
- R9: While aux_en = 0, the mode and ilim_code are frozen and weak_irq stays 0. When aux_en returns to 1, the running period starts again from zero.
- R10: One edge after trickle_done is seen low, the block is idle, with buck_en = 0 and ilim_code = 0.
- R11: A back-off step to a code below LOW_CODE, taken while bat_fet_present, src_ge_500ma, sys_on and bat_below_min are all 1, makes rails_off 1 for one cycle and sets pwr_inhibit, both on the same edge as the step.
- R12: pwr_inhibit stays 1 while bat_below_min = 1 and clears on the edge after bat_below_min is seen 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aux_en | input | 1 | Regulation enable; 0 freezes mode and limit |
| trickle_done | input | 1 | Trickle charge complete; 0 returns the block to idle |
| above_high | input | 1 | Auxiliary input above the high level |
| above_mid | input | 1 | Auxiliary input above the mid level |
| above_weak | input | 1 | Auxiliary input above the weak level |
| bat_fet_present | input | 1 | Battery switch fitted |
| src_ge_500ma | input | 1 | Charger source rated for 500 mA or more |
| sys_on | input | 1 | System powered on |
| bat_below_min | input | 1 | Battery below its minimum operating voltage |
| ilim_code | output | LIM_W | Input current limit code, (k+1) × 100 mA |
| buck_en | output | 1 | Buck power stage enable |
| weak_irq | output | 1 | One-cycle pulse: input too weak at the minimum limit |
| rails_off | output | 1 | One-cycle rail power-down request |
| pwr_inhibit | output | 1 | Power-on inhibit, held until the battery recovers |

## Verification
The hardest situation to reach is the lockout. It needs the limit to have climbed above LOW_CODE first, then a back-off walk down through it with all four battery and system flags already set. The shutdown needs a full walk down to code 0 with the input still weak. The bench shortens the prescaler and both tick counts, ramps to code 4 with the input high, raises the lockout flags, and then drops the comparators below the weak level. Along the way it breaks the back-off off with a recovery into hold. It also removes the enable in the middle of a period, to show that the timer restarts after the freeze.

// File: rtl/aux_ilim_pkg.sv
package aux_ilim_pkg;

    // Operating mode of the regulator
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for trickle charge to finish
        ST_UP   = 3'd1,   // slow increase of the limit
        ST_HOLD = 3'd2,   // limit held inside the window
        ST_DN   = 3'd3,   // fast back-off below weak level
        ST_OFF  = 3'd4    // buck shut down, input too weak
    } ctl_st_e;

    // Where the input sits against the three comparator levels
    typedef enum logic [1:0] {
        Z_WEAK = 2'd0,
        Z_WIN  = 2'd1,
        Z_MID  = 2'd2,
        Z_HIGH = 2'd3
    } zone_e;

    // Comparators are monotonic: high implies mid implies weak.
    function automatic zone_e zone_of(input logic hi, input logic mid, input logic wk);
        zone_e z;
        if (!wk)       z = Z_WEAK;
        else if (!mid) z = Z_WIN;
        else if (!hi)  z = Z_MID;
        else           z = Z_HIGH;
        return z;
    endfunction

endpackage

// File: rtl/aux_ilim_tick.sv
// Shared prescaler: one tick every DIV cycles, restartable.
module aux_ilim_tick #(
    parameter int unsigned DIV = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            typedef struct packed {
                logic [CW-1:0] cnt;
            } tick_st_t;

            tick_st_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (clr || (s_q.cnt == LAST)) begin
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            assign tick = (s_q.cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/aux_ilim_fsm.sv
// Mode control, limit code register and period counter.
module aux_ilim_fsm
    import aux_ilim_pkg::*;
#(
    parameter int unsigned LIM_W      = 3,
    parameter int unsigned RAMP_TICKS = 5000,
    parameter int unsigned BACK_TICKS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aux_en,
    input  logic             trickle_done,
    input  logic             above_high,
    input  logic             above_mid,
    input  logic             above_weak,
    input  logic             tick,
    output logic             tmr_clr,
    output logic             step_dn,
    output logic [LIM_W-1:0] code_next,
    output logic [LIM_W-1:0] ilim_code,
    output logic             buck_en,
    output logic             weak_irq
);
    localparam int unsigned MAXT  = (RAMP_TICKS > BACK_TICKS) ? RAMP_TICKS : BACK_TICKS;
    localparam int unsigned PER_W = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [PER_W-1:0] UP_LAST = PER_W'(RAMP_TICKS - 1);
    localparam logic [PER_W-1:0] DN_LAST = PER_W'(BACK_TICKS - 1);
    localparam logic [LIM_W-1:0] LIM_TOP = '1;

    typedef struct packed {
        ctl_st_e          st;
        logic [LIM_W-1:0] lim;
        logic [PER_W-1:0] per;
        logic             buck;
        logic             irq;
    } fsm_st_t;

    fsm_st_t s_d, s_q;
    zone_e   zone;
    logic    period_end;
    logic    timed;

    always_comb begin
        s_d        = s_q;
        s_d.irq    = 1'b0;
        step_dn    = 1'b0;
        zone       = zone_of(above_high, above_mid, above_weak);
        period_end = tick && (s_q.per == ((s_q.st == ST_UP) ? UP_LAST : DN_LAST));
        timed      = (s_q.st == ST_UP) || (s_q.st == ST_DN);

        if (!trickle_done) begin
            s_d.st   = ST_IDLE;
            s_d.lim  = '0;
            s_d.buck = 1'b0;
        end else if (s_q.st == ST_IDLE) begin
            s_d.st   = ST_UP;
            s_d.lim  = '0;
            s_d.buck = 1'b1;
        end else if (aux_en) begin
            unique case (s_q.st)
                ST_UP: begin
                    if (zone == Z_WEAK) begin
                        s_d.st = ST_DN;
                    end else if (zone == Z_WIN) begin
                        s_d.st = ST_HOLD;
                    end else if (period_end && (s_q.lim != LIM_TOP)) begin
                        s_d.lim = s_q.lim + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (zone == Z_WEAK) begin
                        s_d.st = ST_DN;
                    end else if (zone == Z_HIGH) begin
                        s_d.st = ST_UP;
                    end
                end
                ST_DN: begin
                    if (zone != Z_WEAK) begin
                        s_d.st = ST_HOLD;
                    end else if (period_end) begin
                        if (s_q.lim != '0) begin
                            s_d.lim = s_q.lim - 1'b1;
                            step_dn = 1'b1;
                        end else begin
                            s_d.st   = ST_OFF;
                            s_d.buck = 1'b0;
                            s_d.irq  = 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end

        // Period counter restarts on any mode change or freeze
        tmr_clr = !timed || !aux_en || !trickle_done || (s_d.st != s_q.st);
        if (tmr_clr) begin
            s_d.per = '0;
        end else if (tick) begin
            s_d.per = period_end ? '0 : (s_q.per + 1'b1);
        end

        code_next = s_d.lim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st   <= ST_IDLE;
            s_q.lim  <= '0;
            s_q.per  <= '0;
            s_q.buck <= 1'b0;
            s_q.irq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ilim_code = s_q.lim;
    assign buck_en   = s_q.buck;
    assign weak_irq  = s_q.irq;
endmodule

// File: rtl/aux_ilim_lockout.sv
// Dead-battery lockout on a downward step below the low code.
module aux_ilim_lockout #(
    parameter int unsigned LIM_W    = 3,
    parameter int unsigned LOW_CODE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_dn,
    input  logic [LIM_W-1:0] code_next,
    input  logic             bat_fet_present,
    input  logic             src_ge_500ma,
    input  logic             sys_on,
    input  logic             bat_below_min,
    output logic             rails_off,
    output logic             pwr_inhibit
);
    localparam logic [LIM_W-1:0] LOW_LIM = LIM_W'(LOW_CODE);

    typedef struct packed {
        logic rails;
        logic inh;
    } lock_st_t;

    lock_st_t s_d, s_q;
    logic     trig;

    always_comb begin
        trig      = step_dn && (code_next < LOW_LIM) && bat_fet_present
                    && src_ge_500ma && sys_on && bat_below_min;
        s_d.rails = trig;
        s_d.inh   = trig || (s_q.inh && bat_below_min);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rails_off   = s_q.rails;
    assign pwr_inhibit = s_q.inh;
endmodule

// File: rtl/aux_ilim_ramp.sv
module aux_ilim_ramp #(
    parameter int unsigned LIM_W      = 3,
    parameter int unsigned PRESCALE   = 4000,
    parameter int unsigned RAMP_TICKS = 5000,
    parameter int unsigned BACK_TICKS = 6,
    parameter int unsigned LOW_CODE   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aux_en,
    input  logic             trickle_done,
    input  logic             above_high,
    input  logic             above_mid,
    input  logic             above_weak,
    input  logic             bat_fet_present,
    input  logic             src_ge_500ma,
    input  logic             sys_on,
    input  logic             bat_below_min,
    output logic [LIM_W-1:0] ilim_code,
    output logic             buck_en,
    output logic             weak_irq,
    output logic             rails_off,
    output logic             pwr_inhibit
);
    logic             tick;
    logic             tmr_clr;
    logic             step_dn;
    logic [LIM_W-1:0] code_next;

    aux_ilim_tick #(
        .DIV (PRESCALE)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .tick (tick)
    );

    aux_ilim_fsm #(
        .LIM_W      (LIM_W),
        .RAMP_TICKS (RAMP_TICKS),
        .BACK_TICKS (BACK_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .aux_en       (aux_en),
        .trickle_done (trickle_done),
        .above_high   (above_high),
        .above_mid    (above_mid),
        .above_weak   (above_weak),
        .tick         (tick),
        .tmr_clr      (tmr_clr),
        .step_dn      (step_dn),
        .code_next    (code_next),
        .ilim_code    (ilim_code),
        .buck_en      (buck_en),
        .weak_irq     (weak_irq)
    );

    aux_ilim_lockout #(
        .LIM_W    (LIM_W),
        .LOW_CODE (LOW_CODE)
    ) u_lock (
        .clk             (clk),
        .rst             (rst),
        .step_dn         (step_dn),
        .code_next       (code_next),
        .bat_fet_present (bat_fet_present),
        .src_ge_500ma    (src_ge_500ma),
        .sys_on          (sys_on),
        .bat_below_min   (bat_below_min),
        .rails_off       (rails_off),
        .pwr_inhibit     (pwr_inhibit)
    );
endmodule

// File: rtl/aux_ilim_ramp_chk.sv
module aux_ilim_ramp_chk #(
    parameter int unsigned LIM_W    = 3,
    parameter int unsigned LOW_CODE = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             aux_en,
    input logic             trickle_done,
    input logic             bat_below_min,
    input logic [LIM_W-1:0] ilim_code,
    input logic             buck_en,
    input logic             weak_irq,
    input logic             rails_off,
    input logic             pwr_inhibit
);
    // R3
    up_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ilim_code > $past(ilim_code)) |-> (ilim_code == $past(ilim_code) + 1'b1));

    // R6
    down_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(trickle_done) && (ilim_code < $past(ilim_code)))
        |-> (ilim_code == $past(ilim_code) - 1'b1));

    // R8
    irq_buck_off_chk: assert property (@(posedge clk) disable iff (rst)
        weak_irq |-> (!buck_en && (ilim_code == '0)));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        weak_irq |=> !weak_irq);

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!aux_en && trickle_done) |-> ($stable(ilim_code) && !weak_irq));

    // R10
    idle_return_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!trickle_done) |-> (!buck_en && (ilim_code == '0)));

    // R11
    rails_low_chk: assert property (@(posedge clk) disable iff (rst)
        rails_off |-> (pwr_inhibit && (ilim_code < LIM_W'(LOW_CODE))));

    // R12
    inhibit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!bat_below_min) |-> !pwr_inhibit);
endmodule

bind aux_ilim_ramp aux_ilim_ramp_chk #(
    .LIM_W    (LIM_W),
    .LOW_CODE (LOW_CODE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .aux_en        (aux_en),
    .trickle_done  (trickle_done),
    .bat_below_min (bat_below_min),
    .ilim_code     (ilim_code),
    .buck_en       (buck_en),
    .weak_irq      (weak_irq),
    .rails_off     (rails_off),
    .pwr_inhibit   (pwr_inhibit)
);

// File: tb/aux_ilim_ramp_tb.sv
`timescale 1ns/1ps
module aux_ilim_ramp_tb;
    localparam int LW  = 3;
    localparam int P   = 4;
    localparam int RT  = 5;
    localparam int BT  = 2;
    localparam int LOW = 2;
    localparam int TOPC = (1 << LW) - 1;
    localparam int UPC = P * RT;   // 20 cycles per increase
    localparam int DNC = P * BT;   // 8 cycles per decrease

    logic clk = 1'b0;
    logic rst, aux_en, trickle_done;
    logic bat_fet_present, src_ge_500ma, sys_on, bat_below_min;
    int   lvl;  // 0 below weak, 1 window, 2 between mid and high, 3 above high
    logic above_high, above_mid, above_weak;
    logic [LW-1:0] ilim_code;
    logic buck_en, weak_irq, rails_off, pwr_inhibit;

    assign above_weak = (lvl >= 1);
    assign above_mid  = (lvl >= 2);
    assign above_high = (lvl >= 3);

    always #2.5 clk = ~clk;

    aux_ilim_ramp #(
        .LIM_W(LW), .PRESCALE(P), .RAMP_TICKS(RT), .BACK_TICKS(BT), .LOW_CODE(LOW)
    ) u_dut (
        .clk(clk), .rst(rst), .aux_en(aux_en), .trickle_done(trickle_done),
        .above_high(above_high), .above_mid(above_mid), .above_weak(above_weak),
        .bat_fet_present(bat_fet_present), .src_ge_500ma(src_ge_500ma),
        .sys_on(sys_on), .bat_below_min(bat_below_min),
        .ilim_code(ilim_code), .buck_en(buck_en), .weak_irq(weak_irq),
        .rails_off(rails_off), .pwr_inhibit(pwr_inhibit)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Behavioural reference: mode as a string, plain integers
    string m_mode = "idle";
    int m_lim = 0, m_buck = 0, m_irq = 0, m_rails = 0, m_inh = 0, m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = "idle"; m_lim = 0; m_buck = 0; m_irq = 0;
            m_rails = 0; m_inh = 0; m_cnt = 0;
        end else begin
            m_irq = 0;
            m_rails = 0;
            m_inh = m_inh && bat_below_min;
            if (!trickle_done) begin
                m_mode = "idle"; m_lim = 0; m_buck = 0; m_cnt = 0;
            end else if (m_mode == "idle") begin
                m_mode = "up"; m_lim = 0; m_buck = 1; m_cnt = 0;
            end else if (!aux_en) begin
                m_cnt = 0;
            end else if (m_mode == "up") begin
                if (lvl == 0) begin m_mode = "dn"; m_cnt = 0; end
                else if (lvl == 1) begin m_mode = "hold"; m_cnt = 0; end
                else begin
                    m_cnt++;
                    if (m_cnt == UPC) begin
                        m_cnt = 0;
                        if (m_lim < TOPC) m_lim++;
                    end
                end
            end else if (m_mode == "hold") begin
                m_cnt = 0;
                if (lvl == 0) m_mode = "dn";
                else if (lvl == 3) m_mode = "up";
            end else if (m_mode == "dn") begin
                if (lvl >= 1) begin m_mode = "hold"; m_cnt = 0; end
                else begin
                    m_cnt++;
                    if (m_cnt == DNC) begin
                        m_cnt = 0;
                        if (m_lim > 0) begin
                            m_lim--;
                            if (m_lim < LOW && bat_fet_present && src_ge_500ma
                                && sys_on && bat_below_min) begin
                                m_rails = 1; m_inh = 1;
                            end
                        end else begin
                            m_mode = "off"; m_buck = 0; m_irq = 1;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare with the reference on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(int'(ilim_code), m_lim, cur_req, "model ilim_code");
            chk(int'(buck_en), m_buck, cur_req, "model buck_en");
            chk(int'(weak_irq), m_irq, cur_req, "model weak_irq");
            chk(int'(rails_off), m_rails, cur_req, "model rails_off");
            chk(int'(pwr_inhibit), m_inh, cur_req, "model pwr_inhibit");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; aux_en = 1; trickle_done = 0; lvl = 3;
        bat_fet_present = 0; src_ge_500ma = 0; sys_on = 0; bat_below_min = 0;
        cyc(3);
        chk(int'(ilim_code), 0, "R1", "reset code");
        chk(int'(buck_en), 0, "R1", "reset buck");
        rst = 0;
        cyc(5);
        chk(int'(buck_en), 0, "R1", "idle buck");
        chk(int'(pwr_inhibit), 0, "R1", "idle inhibit");

        cur_req = "R2"; trickle_done = 1; cyc(1);
        chk(int'(buck_en), 1, "R2", "buck on");
        chk(int'(ilim_code), 0, "R2", "start code");

        cur_req = "R3"; cyc(UPC - 1);
        chk(int'(ilim_code), 0, "R3", "before first step");
        cyc(1);
        chk(int'(ilim_code), 1, "R3", "first step");
        cyc(UPC * 6);
        chk(int'(ilim_code), 7, "R3", "top code");
        cyc(UPC * 2);
        chk(int'(ilim_code), 7, "R3", "saturated");

        cur_req = "R10"; trickle_done = 0; cyc(2);
        chk(int'(buck_en), 0, "R10", "buck off idle");
        chk(int'(ilim_code), 0, "R10", "code cleared");
        trickle_done = 1; cyc(1);

        cur_req = "R4"; cyc(2 * UPC + 10);
        chk(int'(ilim_code), 2, "R4", "ramped to 2");
        lvl = 1; cyc(60);
        chk(int'(ilim_code), 2, "R4", "hold in window");
        cur_req = "R5"; lvl = 2; cyc(60);
        chk(int'(ilim_code), 2, "R5", "mid only keeps hold");
        lvl = 3; cyc(UPC);
        chk(int'(ilim_code), 2, "R5", "restarted period");
        cyc(1);
        chk(int'(ilim_code), 3, "R5", "resumed step");
        cyc(UPC);
        chk(int'(ilim_code), 4, "R5", "code 4");

        cur_req = "R6";
        bat_fet_present = 1; src_ge_500ma = 1; sys_on = 1; bat_below_min = 1;
        lvl = 0; cyc(1 + DNC);
        chk(int'(ilim_code), 3, "R6", "first back-off");
        cyc(DNC);
        chk(int'(ilim_code), 2, "R6", "second back-off");
        cur_req = "R11"; cyc(DNC);
        chk(int'(ilim_code), 1, "R11", "step below low");
        chk(int'(rails_off), 1, "R11", "rails pulse");
        chk(int'(pwr_inhibit), 1, "R11", "inhibit set");
        cyc(1);
        chk(int'(rails_off), 0, "R11", "rails pulse ends");

        cur_req = "R7"; lvl = 1; cyc(1 + 30);
        chk(int'(ilim_code), 1, "R7", "recovered hold");
        cur_req = "R8"; lvl = 0; cyc(1 + DNC);
        chk(int'(ilim_code), 0, "R8", "at minimum");
        cyc(DNC);
        chk(int'(buck_en), 0, "R8", "buck shut");
        chk(int'(weak_irq), 1, "R8", "irq pulse");
        cyc(1);
        chk(int'(weak_irq), 0, "R8", "irq single");
        lvl = 3; cyc(40);
        chk(int'(buck_en), 0, "R8", "stays off");
        cur_req = "R12";
        chk(int'(pwr_inhibit), 1, "R12", "inhibit held");
        bat_below_min = 0; cyc(1);
        chk(int'(pwr_inhibit), 0, "R12", "inhibit cleared");

        cur_req = "R9"; trickle_done = 0; cyc(1); trickle_done = 1; cyc(1);
        cyc(2 * UPC + 5);
        chk(int'(ilim_code), 2, "R9", "pre-freeze");
        aux_en = 0; cyc(50);
        chk(int'(ilim_code), 2, "R9", "frozen");
        aux_en = 1; cyc(UPC - 1);
        chk(int'(ilim_code), 2, "R9", "timer restarted");
        cyc(1);
        chk(int'(ilim_code), 3, "R9", "step after enable");
        lvl = 0; cyc(5); aux_en = 0; cyc(40);
        chk(int'(ilim_code), 3, "R9", "back-off frozen");
        chk(int'(weak_irq), 0, "R9", "no irq while off");
        aux_en = 1; cyc(DNC);
        chk(int'(ilim_code), 2, "R9", "back-off resumes");
        cyc(5);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule